// File: doc/BRIEF.md
# Pipeline Interlock and Redirect Controller

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may advance. The pipeline has no bypass paths, so an instruction in decode that reads a register still being produced by an older instruction in execute or memory waits in decode. While it waits, the program counter and the decode register hold and an empty slot enters execute. A producer that has reached writeback no longer blocks, because the register file writes early in the cycle and decode reads the new value in the same cycle.

Branches are handled without prediction. When a branch sits in decode, fetch freezes for one cycle and decode receives an empty slot, so no instruction after the branch is fetched before its outcome is known. The branch resolves in execute. A taken or mispredicted branch raises a redirect that loads the target into the program counter and empties decode and execute. If instruction and data fetches share one memory port (a parameter), a memory-stage access blocks the fetch for that cycle. The block is purely combinational; the clock and reset serve the embedded checks only.

Top module: `pipe_interlock`

## Requirements
- R1: When decode holds a valid instruction that reads a non-zero register written by a valid producer in execute, the controller raises pc_hold, id_hold and ex_bubble, and keeps id_kill and redirect low.
- R2: The same stall as in R1 occurs when the matching producer is in the memory stage.
- R3: Only producers in execute and memory are compared; with no match there, decode advances (all five controls low), which is how a producer in writeback is treated as ready.
- R4: No stall occurs if the read register is 0, if the producer's write enable is low, if the source's read flag is low, or if id_valid is low.
- R5: A branch in decode that is not stalled raises pc_hold and id_kill while id_hold and ex_bubble stay low.
- R6: A branch in execute with ex_redirect high raises redirect, id_kill and ex_bubble and forces pc_hold and id_hold low, overriding any register stall, branch freeze or port conflict.
- R7: A branch in execute with ex_redirect low raises no redirect and lets fetch continue.
- R8: With SHARED_PORT = 1, mem_port_use raises pc_hold and id_kill while the decode instruction still advances (ex_bubble low); with SHARED_PORT = 0 it has no effect.
- R9: A register stall takes precedence over a branch freeze and a port conflict: id_hold stays high and id_kill stays low.
- R10: ex_redirect has no effect unless ex_branch is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| id_valid | input | 1 | Decode holds a real instruction |
| id_src_idx | input | NUM_SRC x 5 | Register numbers read by decode, source 0 in the low slice |
| id_src_rd | input | NUM_SRC | Per-source flag: the source is actually read |
| id_branch | input | 1 | The decode instruction is a branch |
| ex_wen | input | 1 | Execute holds a valid register-writing instruction |
| ex_rd | input | 5 | Destination register in execute |
| mem_wen | input | 1 | Memory stage holds a valid register-writing instruction |
| mem_rd | input | 5 | Destination register in the memory stage |
| ex_branch | input | 1 | Execute holds a branch |
| ex_redirect | input | 1 | The branch in execute is taken or mispredicted |
| mem_port_use | input | 1 | Memory stage accesses the shared port this cycle |
| pc_hold | output | 1 | Program counter keeps its value |
| id_hold | output | 1 | Decode register keeps its contents |
| id_kill | output | 1 | Decode register loads an empty slot |
| ex_bubble | output | 1 | Execute register loads an empty slot |
| redirect | output | 1 | Program counter loads the resolved branch target |

## Verification
The checks assume the inputs are stable between clock edges and that write enables are low for empty stages, so a destination field is never compared for an empty slot. They also take for granted that ex_redirect is only meaningful alongside ex_branch, which R10 pins down explicitly. The stimulus drives every input pattern a half period away from the rising edge and holds it across that edge, and it includes the cases where ex_redirect is raised without a branch and where destination fields carry stale numbers with their enable low.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;

    localparam int unsigned RA_W = 5;

    typedef logic [RA_W-1:0] reg_idx_t;

    typedef struct packed {
        logic     wen;
        reg_idx_t rd;
    } dest_t;

    typedef struct packed {
        logic pc_hold;
        logic id_hold;
        logic id_kill;
        logic ex_bubble;
        logic redirect;
    } ctl_t;

    // A source is blocked by a producer only when it names a real register
    function automatic logic dest_blocks(input reg_idx_t src, input dest_t d);
        return d.wen && (src == d.rd) && (src != '0);
    endfunction

endpackage

// File: rtl/hazard_raw.sv
module hazard_raw
    import pipe_ctl_pkg::*;
#(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                           valid,
    input  logic [NUM_SRC-1:0][RA_W-1:0]   src_idx,
    input  logic [NUM_SRC-1:0]             src_rd,
    input  dest_t                          ex_dst,
    input  dest_t                          mem_dst,
    output logic                           stall
);

    logic [NUM_SRC-1:0] src_hit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_hit[s] = src_rd[s] &&
                            (dest_blocks(src_idx[s], ex_dst) ||
                             dest_blocks(src_idx[s], mem_dst));
    end

    assign stall = valid && (|src_hit);

endmodule

// File: rtl/fetch_gate.sv
module fetch_gate #(
    parameter bit SHARED_PORT = 1'b1
) (
    input  logic mem_port_use,
    output logic port_conflict
);

    if (SHARED_PORT) begin : g_shared
        assign port_conflict = mem_port_use;
    end else begin : g_split
        logic unused_use;
        assign unused_use    = mem_port_use;
        assign port_conflict = 1'b0;
    end

endmodule

// File: rtl/ctl_priority.sv
module ctl_priority
    import pipe_ctl_pkg::*;
(
    input  logic flush,
    input  logic raw_stall,
    input  logic br_decode,
    input  logic port_conflict,
    output ctl_t ctl
);

    always_comb begin
        ctl = '0;
        if (flush) begin
            ctl.id_kill   = 1'b1;
            ctl.ex_bubble = 1'b1;
            ctl.redirect  = 1'b1;
        end else if (raw_stall) begin
            ctl.pc_hold   = 1'b1;
            ctl.id_hold   = 1'b1;
            ctl.ex_bubble = 1'b1;
        end else if (br_decode || port_conflict) begin
            ctl.pc_hold   = 1'b1;
            ctl.id_kill   = 1'b1;
        end
    end

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pipe_ctl_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 2,
    parameter bit          SHARED_PORT = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         id_valid,
    input  logic [NUM_SRC-1:0][RA_W-1:0] id_src_idx,
    input  logic [NUM_SRC-1:0]           id_src_rd,
    input  logic                         id_branch,
    input  logic                         ex_wen,
    input  logic [RA_W-1:0]              ex_rd,
    input  logic                         mem_wen,
    input  logic [RA_W-1:0]              mem_rd,
    input  logic                         ex_branch,
    input  logic                         ex_redirect,
    input  logic                         mem_port_use,
    output logic                         pc_hold,
    output logic                         id_hold,
    output logic                         id_kill,
    output logic                         ex_bubble,
    output logic                         redirect
);

    dest_t ex_dst;
    dest_t mem_dst;
    logic  raw_stall;
    logic  port_conflict;
    logic  flush;
    logic  br_decode;
    ctl_t  ctl;

    assign ex_dst    = '{wen: ex_wen,  rd: ex_rd};
    assign mem_dst   = '{wen: mem_wen, rd: mem_rd};
    assign flush     = ex_branch && ex_redirect;
    assign br_decode = id_valid && id_branch;

    hazard_raw #(.NUM_SRC(NUM_SRC)) raw_i (
        .valid   (id_valid),
        .src_idx (id_src_idx),
        .src_rd  (id_src_rd),
        .ex_dst  (ex_dst),
        .mem_dst (mem_dst),
        .stall   (raw_stall)
    );

    fetch_gate #(.SHARED_PORT(SHARED_PORT)) gate_i (
        .mem_port_use  (mem_port_use),
        .port_conflict (port_conflict)
    );

    ctl_priority prio_i (
        .flush         (flush),
        .raw_stall     (raw_stall),
        .br_decode     (br_decode),
        .port_conflict (port_conflict),
        .ctl           (ctl)
    );

    assign pc_hold   = ctl.pc_hold;
    assign id_hold   = ctl.id_hold;
    assign id_kill   = ctl.id_kill;
    assign ex_bubble = ctl.ex_bubble;
    assign redirect  = ctl.redirect;

    // R1 / R2: a held decode always pairs with a frozen PC and an empty execute slot
    p_hold_pairs_r1: assert property (@(posedge clk) disable iff (rst)
        id_hold |-> (pc_hold && ex_bubble && !id_kill && !redirect));

    // R6: a resolved redirect wins over every stall source
    p_flush_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (ex_branch && ex_redirect) |->
            (redirect && id_kill && ex_bubble && !pc_hold && !id_hold));

    // R10: no redirect without a branch in execute
    p_no_branch_r10: assert property (@(posedge clk) disable iff (rst)
        !ex_branch |-> !redirect);

    // R4: an empty decode slot never stalls
    p_empty_decode_r4: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !id_hold);

    // R5: a branch leaving decode freezes fetch
    p_branch_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_branch && !id_hold && !redirect) |-> (pc_hold && id_kill));

    // R9: decode is never both kept and emptied
    p_hold_kill_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(id_hold && id_kill));

endmodule

// File: tb/pipe_interlock_tb_top.sv
module pipe_interlock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 16;
    localparam int WATCHDOG   = 5000;

    // {req[3:0], id_valid, rs1, rs2, rs1_rd, rs2_rd, id_branch,
    //  ex_wen, ex_rd, mem_wen, mem_rd, ex_branch, ex_redirect, mem_port_use,
    //  exp {pc_hold, id_hold, id_kill, ex_bubble, redirect}}
    localparam logic [37:0] VEC [NV] = '{
        {4'd1,  1'b1, 5'd3, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b11010}, // R1 rs1
        {4'd1,  1'b1, 5'd1, 5'd7, 1'b1, 1'b1, 1'b0, 1'b1, 5'd7, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b11010}, // R1 rs2
        {4'd2,  1'b1, 5'd9, 5'd2, 1'b1, 1'b1, 1'b0, 1'b0, 5'd9, 1'b1, 5'd9, 1'b0, 1'b0, 1'b0, 5'b11010}, // R2
        {4'd3,  1'b1, 5'd4, 5'd5, 1'b1, 1'b1, 1'b0, 1'b1, 5'd6, 1'b1, 5'd8, 1'b0, 1'b0, 1'b0, 5'b00000}, // R3
        {4'd4,  1'b1, 5'd0, 5'd5, 1'b1, 1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R4 reg 0
        {4'd4,  1'b1, 5'd3, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 5'd3, 1'b0, 5'd5, 1'b0, 1'b0, 1'b0, 5'b00000}, // R4 wen low
        {4'd4,  1'b1, 5'd3, 5'd5, 1'b0, 1'b1, 1'b0, 1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R4 not read
        {4'd4,  1'b0, 5'd3, 5'd5, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 5'b00000}, // R4 empty
        {4'd5,  1'b1, 5'd2, 5'd6, 1'b1, 1'b1, 1'b1, 1'b1, 5'd9, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b10100}, // R5
        {4'd6,  1'b1, 5'd3, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 5'b00111}, // R6 vs raw
        {4'd6,  1'b1, 5'd2, 5'd4, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 5'b00111}, // R6 vs port
        {4'd7,  1'b1, 5'd2, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 5'd9, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 5'b00000}, // R7
        {4'd8,  1'b1, 5'd2, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b10100}, // R8
        {4'd9,  1'b1, 5'd5, 5'd4, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 5'd4, 1'b0, 1'b0, 1'b0, 5'b11010}, // R9 branch
        {4'd9,  1'b1, 5'd5, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 5'd5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'b11010}, // R9 port
        {4'd10, 1'b1, 5'd2, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 5'b00000}  // R10
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           id_valid = 1'b0;
    logic [1:0][4:0] id_src_idx = '0;
    logic [1:0]     id_src_rd = '0;
    logic           id_branch = 1'b0;
    logic           ex_wen = 1'b0;
    logic [4:0]     ex_rd = '0;
    logic           mem_wen = 1'b0;
    logic [4:0]     mem_rd = '0;
    logic           ex_branch = 1'b0;
    logic           ex_redirect = 1'b0;
    logic           mem_port_use = 1'b0;
    logic           pc_hold, id_hold, id_kill, ex_bubble, redirect;
    logic           np_pc_hold, np_id_hold, np_id_kill, np_ex_bubble, np_redirect;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_interlock #(.NUM_SRC(2), .SHARED_PORT(1'b1)) dut_i (
        .clk, .rst, .id_valid, .id_src_idx, .id_src_rd, .id_branch,
        .ex_wen, .ex_rd, .mem_wen, .mem_rd, .ex_branch, .ex_redirect,
        .mem_port_use, .pc_hold, .id_hold, .id_kill, .ex_bubble, .redirect
    );

    pipe_interlock #(.NUM_SRC(2), .SHARED_PORT(1'b0)) dut_np (
        .clk, .rst, .id_valid, .id_src_idx, .id_src_rd, .id_branch,
        .ex_wen, .ex_rd, .mem_wen, .mem_rd, .ex_branch, .ex_redirect,
        .mem_port_use,
        .pc_hold(np_pc_hold), .id_hold(np_id_hold), .id_kill(np_id_kill),
        .ex_bubble(np_ex_bubble), .redirect(np_redirect)
    );

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: controls got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [28:0] v);
        @(negedge clk);
        {id_valid, id_src_idx[0], id_src_idx[1], id_src_rd[0], id_src_rd[1], id_branch,
         ex_wen, ex_rd, mem_wen, mem_rd, ex_branch, ex_redirect, mem_port_use} = v;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        // reset state: idle inputs give all controls low
        repeat (2) @(negedge clk);
        #(CLK_PERIOD/4);
        check("R4 reset", {pc_hold, id_hold, id_kill, ex_bubble, redirect}, 5'b00000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][33:5]);
            check($sformatf("R%0d vec%0d", VEC[i][37:34], i),
                  {pc_hold, id_hold, id_kill, ex_bubble, redirect}, VEC[i][4:0]);
        end

        // R8: split ports ignore memory-stage accesses
        drive({1'b1, 5'd2, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1});
        check("R8 split port", {np_pc_hold, np_id_hold, np_id_kill, np_ex_bubble, np_redirect}, 5'b00000);

        // R3: producer leaves memory, decode proceeds in the same cycle
        drive({1'b1, 5'd12, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 5'd12, 1'b0, 1'b0, 1'b0});
        check("R2 mem producer", {pc_hold, id_hold, id_kill, ex_bubble, redirect}, 5'b11010);
        drive({1'b1, 5'd12, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0});
        check("R3 producer in writeback", {pc_hold, id_hold, id_kill, ex_bubble, redirect}, 5'b00000);

        // R5 then R7: branch sequence, decode empty while it resolves not taken
        drive({1'b1, 5'd1, 5'd2, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0});
        check("R5 branch in decode", {pc_hold, id_hold, id_kill, ex_bubble, redirect}, 5'b10100);
        drive({1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0});
        check("R7 not taken", {pc_hold, id_hold, id_kill, ex_bubble, redirect}, 5'b00000);

        drive('0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule